// File: doc/BRIEF.md
# Overtemperature Throttle Output Comparator

This block watches three temperature channels (slice 0 is remote 1, slice 1 is the local sensor, slice 2 is remote 2). Each channel has its own critical limit. When any enabled channel runs hotter than its limit, the block pulls a shared active-low throttle line low. A processor-throttle pin or a fail-safe cooling path can sense this line. The block converts no temperatures itself. A converter upstream supplies each channel's reading and pulses that channel's strobe when a fresh reading is ready. A channel is judged only on those pulses, so its verdict holds for the whole monitoring cycle until the next one.

Readings are 10-bit codes in steps of 0.25 °C. Limits are 8-bit codes in steps of 1 °C. One mode input selects the encoding for all channels. In offset-64 mode the codes are unsigned and zero means −64 °C. In two's-complement mode the codes are signed. A channel is switched off either by clearing its enable bit or by programming its limit to the lowest value the encoding can hold.

Top module: `therm_throttle`

## Requirements
- R1: While reset is held and after it is released, every channel is untripped and `therm_n_o` is high until some strobe trips a channel.
- R2: On a strobe, a channel trips when its reading is at least 0.25 °C above its limit (the reading, in quarter degrees, is strictly greater than four times the limit). A reading exactly equal to the limit does not trip.
- R3: A tripped channel stays tripped at each later strobe where its reading is still above the limit. It releases at the first strobe where the reading is equal to or below the limit.
- R4: A channel's state changes only on the clock edge where its own strobe bit is high. Changes to its reading, limit, enable or the mode between strobes have no effect on the output.
- R5: A channel whose enable bit is low at its strobe becomes untripped, whatever its reading.
- R6: With `mode_i` = 0 (offset-64), the reading code equals (T + 64)·4 and the limit code equals L + 64, both unsigned.
- R7: With `mode_i` = 1 (two's complement), the reading code equals T·4 and the limit code equals L, both signed.
- R8: A limit code of 0x00 in offset-64 mode (−64 °C) or 0x80 in two's-complement mode (−128 °C) disables the channel. At its strobe the channel becomes untripped even when the reading lies above that limit.
- R9: `therm_n_o` is low exactly when at least one channel is tripped. It returns high only once every channel has released.
- R10: A strobe on one channel never changes the state of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Encoding: 0 offset-64, 1 two's complement |
| valid_i | input | 3 | Per-channel strobe marking a fresh reading (bit 0 remote 1, bit 1 local, bit 2 remote 2) |
| temp_i | input | 30 | Three 10-bit readings, channel c at bits [10c+9:10c], 0.25 °C per LSB |
| limit_i | input | 24 | Three 8-bit limits, channel c at bits [8c+7:8c], 1 °C per LSB |
| en_i | input | 3 | Per-channel enable for driving the throttle line |
| therm_n_o | output | 1 | Active-low throttle level |

## Verification
The bench targets the quarter-degree boundary. A reading equal to the limit must leave the line high, and a reading one LSB higher must pull it low. A design using greater-or-equal would throttle 0.25 °C too early, and one that drops the fractional bits would miss the trip entirely. The bench also toggles readings and enables between strobes, where a design that evaluates continuously would release or trip mid-cycle. It programs the two disabling limit codes against readings just above them, where a plain comparator would trip. It keeps two channels hot and releases one, which catches a design that lets a single release clear the shared line. Both encodings are exercised with negative limits, where mixing signed and unsigned compares gives the wrong verdict.

// File: rtl/therm_pkg.sv
package therm_pkg;
  typedef enum logic {
    ENC_OFS64 = 1'b0,
    ENC_TWOS  = 1'b1
  } enc_e;
endpackage

// File: rtl/therm_chan.sv
module therm_chan
  import therm_pkg::*;
#(
  parameter int TW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  enc_e          enc,
  input  logic          valid,
  input  logic [TW-1:0] temp,
  input  logic [LW-1:0] limit,
  input  logic          en,
  output logic          hot_o,
  output logic          off_o,
  output logic          trip_o
);
  localparam int FW = TW - LW;
  localparam int CW = TW + 1;
  localparam logic signed [CW-1:0] OFS_T = CW'(1 << (TW - 2));

  // Reading in signed quarter degrees
  function automatic logic signed [CW-1:0] temp_q(input logic [TW-1:0] c, input enc_e e);
    if (e == ENC_TWOS) return signed'({c[TW-1], c});
    return signed'({1'b0, c}) - OFS_T;
  endfunction

  // Limit scaled to quarter degrees
  function automatic logic signed [CW-1:0] limit_q(input logic [LW-1:0] l, input enc_e e);
    if (e == ENC_TWOS) return signed'({l[LW-1], l, {FW{1'b0}}});
    return signed'({1'b0, l, {FW{1'b0}}}) - OFS_T;
  endfunction

  // Lowest code of each encoding turns the channel off
  function automatic logic limit_off(input logic [LW-1:0] l, input enc_e e);
    if (e == ENC_TWOS) return l == {1'b1, {(LW-1){1'b0}}};
    return l == '0;
  endfunction

  logic signed [CW-1:0] tq, lq;
  logic trip_q;

  always_comb begin
    tq    = temp_q(temp, enc);
    lq    = limit_q(limit, enc);
    hot_o = tq > lq;
    off_o = limit_off(limit, enc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     trip_q <= 1'b0;
    else if (valid) trip_q <= en && !off_o && hot_o;
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/therm_merge.sv
module therm_merge #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] trip,
  output logic           level_n
);
  assign level_n = ~|trip;
endmodule

// File: rtl/therm_throttle.sv
module therm_throttle
  import therm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 10,
  parameter int LW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [NCH-1:0]    valid_i,
  input  logic [NCH*TW-1:0] temp_i,
  input  logic [NCH*LW-1:0] limit_i,
  input  logic [NCH-1:0]    en_i,
  output logic              therm_n_o
);
  logic [NCH-1:0] trip_w;
  logic [NCH-1:0] hot_w;
  logic [NCH-1:0] off_w;
  enc_e enc_w;

  assign enc_w = enc_e'(mode_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    therm_chan #(.TW(TW), .LW(LW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .enc    (enc_w),
      .valid  (valid_i[c]),
      .temp   (temp_i[c*TW +: TW]),
      .limit  (limit_i[c*LW +: LW]),
      .en     (en_i[c]),
      .hot_o  (hot_w[c]),
      .off_o  (off_w[c]),
      .trip_o (trip_w[c])
    );
  end

  therm_merge #(.NCH(NCH)) u_merge (
    .trip    (trip_w),
    .level_n (therm_n_o)
  );
endmodule

// File: rtl/therm_throttle_chk.sv
module therm_throttle_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] valid_i,
  input logic [NCH-1:0] en_i,
  input logic [NCH-1:0] trip_w,
  input logic [NCH-1:0] hot_w,
  input logic [NCH-1:0] off_w,
  input logic           therm_n_o
);
  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (trip_w == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_trip_when_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i[c] && en_i[c] && !off_w[c] && hot_w[c] |=> trip_w[c]);
    assert_release_when_cool_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i[c] && !hot_w[c] |=> !trip_w[c]);
    assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i[c] |=> $stable(trip_w[c]));
    assert_enable_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i[c] && !en_i[c] |=> !trip_w[c]);
    assert_floor_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i[c] && off_w[c] |=> !trip_w[c]);
  end

  assert_assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(therm_n_o) |-> $past(|valid_i));
  assert_release_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_n_o) |-> $past(|valid_i));
endmodule

bind therm_throttle therm_throttle_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .en_i      (en_i),
  .trip_w    (trip_w),
  .hot_w     (hot_w),
  .off_w     (off_w),
  .therm_n_o (therm_n_o)
);

// File: tb/sim_therm_throttle.sv
module sim_therm_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int TW = 10;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic [NCH-1:0] valid_i = '0;
  logic [NCH*TW-1:0] temp_i = '0;
  logic [NCH*LW-1:0] limit_i = '0;
  logic [NCH-1:0] en_i = '0;
  logic therm_n_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";
  bit m_trip [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_throttle #(.NCH(NCH), .TW(TW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .valid_i(valid_i),
    .temp_i(temp_i), .limit_i(limit_i), .en_i(en_i), .therm_n_o(therm_n_o)
  );

  // Behavioural reference: degrees as integers, quarter degrees for readings
  function automatic bit ref_trip(int c);
    int t, l;
    bit off;
    t = int'(temp_i[c*TW +: TW]);
    l = int'(limit_i[c*LW +: LW]);
    if (mode_i) begin
      if (t >= 512) t = t - 1024;
      if (l >= 128) l = l - 256;
      off = (l == -128);
    end else begin
      t = t - 256;
      l = l - 64;
      off = (l == -64);
    end
    return en_i[c] && !off && (t > l * 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) m_trip[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) if (valid_i[c]) m_trip[c] = ref_trip(c);
    end
  end

  task automatic compare();
    bit any = 0;
    for (int c = 0; c < NCH; c++) any |= m_trip[c];
    n_cmp++;
    if (therm_n_o !== !any) begin
      n_bad++;
      $display("FAIL %s: therm_n_o=%b expected %b at %0t", cur_req, therm_n_o, !any, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic set_ch(int c, int t, int l, bit e);
    temp_i[c*TW +: TW] = TW'(t);
    limit_i[c*LW +: LW] = LW'(l);
    en_i[c] = e;
  endtask

  task automatic strobe(logic [NCH-1:0] m);
    valid_i = m;
    tick();
    valid_i = '0;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Expected output level at the current negedge, stated per scenario
  task automatic expect_level(bit lvl);
    n_cmp++;
    if (therm_n_o !== lvl) begin
      n_bad++;
      $display("FAIL %s: therm_n_o=%b expected %b (directed) at %0t", cur_req, therm_n_o, lvl, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    set_ch(0, 1000, 1, 1); set_ch(1, 1000, 1, 1); set_ch(2, 1000, 1, 1);
    valid_i = '1;
    repeat (3) begin @(negedge clk); expect_level(1'b1); compare(); end
    valid_i = '0;
    @(negedge clk); rst_n = 1'b1;
    tick(); expect_level(1'b1);

    // R6 + R2: offset-64, limit 36 C (code 100), reading equal then +0.25
    cur_req = "R6";
    mode_i = 1'b0;
    set_ch(0, 400, 100, 1); set_ch(1, 0, 100, 1); set_ch(2, 0, 100, 1);
    strobe(3'b001); expect_level(1'b1);
    cur_req = "R2";
    set_ch(0, 401, 100, 1);
    strobe(3'b001); expect_level(1'b0);

    // R4: reading cools with no strobe, output holds
    cur_req = "R4";
    set_ch(0, 0, 100, 0);
    mode_i = 1'b1;
    repeat (4) begin tick(); expect_level(1'b0); end
    mode_i = 1'b0;

    // R3: still hot holds, equal releases
    cur_req = "R3";
    set_ch(0, 402, 100, 1);
    strobe(3'b001); expect_level(1'b0);
    set_ch(0, 400, 100, 1);
    strobe(3'b001); expect_level(1'b1);

    // R5: hot but disabled
    cur_req = "R5";
    set_ch(0, 900, 100, 0);
    strobe(3'b001); expect_level(1'b1);

    // R7: two's complement, limit -10 C (0xF6), reading -10 C then -9.75 C
    cur_req = "R7";
    mode_i = 1'b1;
    set_ch(1, 10'h3D8, 8'hF6, 1);
    strobe(3'b010); expect_level(1'b1);
    set_ch(1, 10'h3D9, 8'hF6, 1);
    strobe(3'b010); expect_level(1'b0);
    set_ch(1, 10'h3D8, 8'hF6, 1);
    strobe(3'b010); expect_level(1'b1);

    // R8: disabling floors in both encodings
    cur_req = "R8";
    set_ch(2, 10'h204, 8'h80, 1);     // -127 C against -128 C limit
    strobe(3'b100); expect_level(1'b1);
    set_ch(2, 10'h208, 8'h81, 1);     // -126 C against -127 C: live, trips
    strobe(3'b100); expect_level(1'b0);
    mode_i = 1'b0;
    set_ch(2, 1, 0, 1);               // -63.75 C against -64 C floor
    strobe(3'b100); expect_level(1'b1);

    // R9 + R10: two channels hot, release one, then the other
    cur_req = "R10";
    set_ch(0, 500, 100, 1); set_ch(1, 500, 100, 1); set_ch(2, 0, 100, 1);
    strobe(3'b011); expect_level(1'b0);
    set_ch(1, 0, 100, 1);
    set_ch(0, 0, 100, 1);             // cool but not strobed
    strobe(3'b010); expect_level(1'b0);
    cur_req = "R9";
    strobe(3'b001); expect_level(1'b1);

    // R9: random traffic against the reference on every clock
    for (int i = 0; i < 3000; i++) begin
      valid_i = NCH'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) mode_i = ~mode_i;
      for (int c = 0; c < NCH; c++) begin
        int lim = (c == 0) ? 100 : int'($urandom_range(0, 255));
        if ($urandom_range(0, 7) == 0) lim = mode_i ? 128 : 0;
        set_ch(c, (lim * 4 + int'($urandom_range(0, 8)) - 4 - (mode_i ? 0 : 0)) & 1023,
               lim, $urandom_range(0, 5) != 0);
        if (!mode_i) temp_i[c*TW +: TW] = TW'(((lim - 64) * 4 + 256 + int'($urandom_range(0, 8)) - 4) & 1023);
      end
      tick();
    end
    finish_run();
  end
endmodule